// File: doc/BRIEF.md
# Mailbox Program Download Sequencer

This block sits on the host side of a register mailbox and loads program code into a coprocessor's instruction memory. After reset it keeps reading the coprocessor's outgoing request register until it reads the start-loading request. It then walks a local code image one entry per cycle. Each entry carries a code word, a flag saying whether that program address exists in the image, and a tag saying whether the entry is code or data. Every entry stands for the program address equal to its index.

Present code words are gathered into write bursts. A burst opens by writing its destination address into mailbox data slot 0. The words then go into slots 1 to n, and the burst closes with a write command of 0xA0 + n. A burst closes when it holds 15 words, when an absent address breaks the run, or when the code ends. The code ends at the first entry tagged as data, or at the end of the image. A finish command follows the last burst. The status register is read, and its busy bit must read clear, before every burst is opened and before every command is written. If busy stays set too long, the block stops with an error flag.

States: `ST_IDLE` leads to `ST_REQ_RD`/`ST_REQ_CHK`, the request poll, which moves to `ST_SCAN` on the request. `ST_SCAN` walks the image. It goes to `ST_BSY_RD`/`ST_BSY_CHK`, the busy poll, to open a burst, close a burst or finish. After the poll, control goes to `ST_OPEN` (write the destination, back to scan), `ST_CMD` (write the burst command, back to scan) or `ST_FIN` (finish command). `ST_FIN` leads to `ST_DONE` (one-cycle pulse) and then `ST_HALT`. A busy timeout leads from `ST_BSY_CHK` to `ST_ERR`.

Top module: `mbx_boot_seq`

## Requirements
- R1: No bus write takes place until a read of the request register (address 0x42) has returned 0x001F; until then the block only keeps reading that register.
- R2: Every burst command written to the command register (address 0x40) has the value 0xA0 + n with n from 1 to 15, where n is the number of words in the burst.
- R3: For each burst, data slot 0 (address 0x20) holds the destination program address, and slots 1..n (addresses 0x21..0x20+n) hold the words of consecutive program addresses starting at that destination, when the command is written.
- R4: Every command write is preceded two cycles earlier by a read of the status register (address 0x41), and that read returned bit 7 (busy) clear; no command is written while the mailbox is busy.
- R5: Entries flagged absent are never sent; an absent entry closes any open burst, and the next present entry opens a new burst at its own address.
- R6: Loading stops at the first entry whose data tag is set, or after the last image entry; no later entry is sent.
- R7: After the final burst, the finish command 0x001F is written to the command register exactly once, after a busy-clear status read.
- R8: `boot_done` is high for exactly one cycle, in the cycle after the finish command write.
- R9: If timeout_lim+1 consecutive status reads all show busy set, `boot_err` rises and stays high, and the block makes no further bus access and never signals done.
- R10: After reset, `boot_done`, `boot_err` and `bus_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | output | 8 | Mailbox register address |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe; data is expected on bus_rdata in the following cycle |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_rd |
| img_idx | output | 7 | Image entry index (program address) being examined |
| img_present | input | 1 | The indexed address exists in the image |
| img_is_data | input | 1 | The indexed entry is tagged as data (end of code) |
| img_word | input | 16 | Code word of the indexed entry |
| timeout_lim | input | 16 | Busy-poll limit for the error flag |
| boot_done | output | 1 | One-cycle pulse once the finish command is written |
| boot_err | output | 1 | Sticky busy-timeout error |

## Verification
The bench targets the burst boundaries. A run of exactly 15 words must give one full burst. A run of 20 words must give a second burst at address 15, and a design that counts to 16, or forgets to reopen with a fresh destination, shows a wrong command or a wrong slot 0. Images with scattered gaps, present words placed after the data tag, a data tag at entry 0 and a fully populated image catch a design that sends absent or data entries, fails to split a burst at a gap, or runs past the end. A mailbox that stays busy forever checks that the error rises after exactly timeout_lim+1 busy reads and that nothing is written. A deliberately slow busy release catches any command written while busy.

// File: rtl/mbx_boot_pkg.sv
package mbx_boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ_RD,
        ST_REQ_CHK,
        ST_SCAN,
        ST_BSY_RD,
        ST_BSY_CHK,
        ST_OPEN,
        ST_CMD,
        ST_FIN,
        ST_DONE,
        ST_HALT,
        ST_ERR
    } boot_state_e;

    // Action to take once the busy poll reads clear
    typedef enum logic [1:0] {
        PD_OPEN,
        PD_BURST,
        PD_FIN
    } pend_e;

    localparam logic [7:0] START_REQ  = 8'h1F;
    localparam logic [7:0] FINISH_CMD = 8'h1F;
    localparam logic [7:0] WRITE_CMD  = 8'hA0;

endpackage

// File: rtl/mbx_boot_timer.sv
module mbx_boot_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/mbx_boot_burst.sv
module mbx_boot_burst #(
    parameter int MAX_BURST = 15,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          last
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CW'(1);
        end
    end

    // The word being added now fills the burst
    assign last = (count == CW'(MAX_BURST - 1));

endmodule

// File: rtl/mbx_boot_seq.sv
module mbx_boot_seq
    import mbx_boot_pkg::*;
#(
    parameter int             AW        = 8,
    parameter int             DW        = 16,
    parameter int             IMG_DEPTH = 64,
    parameter int             MAX_BURST = 15,
    parameter int             TW        = 16,
    parameter int             BUSY_BIT  = 7,
    parameter logic [AW-1:0]  CMD_ADDR  = 8'h40,
    parameter logic [AW-1:0]  STAT_ADDR = 8'h41,
    parameter logic [AW-1:0]  REQ_ADDR  = 8'h42,
    parameter logic [AW-1:0]  DATA_BASE = 8'h20,
    localparam int            IAW       = $clog2(IMG_DEPTH + 1),
    localparam int            CW        = $clog2(MAX_BURST + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_wr,
    output logic           bus_rd,
    input  logic [DW-1:0]  bus_rdata,
    output logic [IAW-1:0] img_idx,
    input  logic           img_present,
    input  logic           img_is_data,
    input  logic [DW-1:0]  img_word,
    input  logic [TW-1:0]  timeout_lim,
    output logic           boot_done,
    output logic           boot_err
);

    boot_state_e    state, state_n;
    pend_e          pend, pend_n;
    logic [IAW-1:0] idx, idx_n;
    logic           opened, opened_n;
    logic           b_inc, b_clr, b_last;
    logic [CW-1:0]  b_cnt;
    logic           t_clr, t_tick, t_exp;
    logic           busy, scan_end, scan_wr;

    mbx_boot_burst #(.MAX_BURST(MAX_BURST), .CW(CW)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (b_inc),
        .clr   (b_clr),
        .count (b_cnt),
        .last  (b_last)
    );

    mbx_boot_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (t_clr),
        .tick    (t_tick),
        .limit   (timeout_lim),
        .expired (t_exp)
    );

    assign img_idx  = idx;
    assign busy     = bus_rdata[BUSY_BIT];
    assign scan_end = (idx == IAW'(IMG_DEPTH)) || img_is_data;
    assign scan_wr  = (state == ST_SCAN) && !scan_end && img_present && opened;
    assign t_clr    = (state != ST_BSY_RD) && (state != ST_BSY_CHK);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= PD_FIN;
            idx    <= '0;
            opened <= 1'b0;
        end else begin
            state  <= state_n;
            pend   <= pend_n;
            idx    <= idx_n;
            opened <= opened_n;
        end
    end

    // Transitions
    always_comb begin
        state_n  = state;
        pend_n   = pend;
        idx_n    = idx;
        opened_n = opened;
        b_inc    = 1'b0;
        b_clr    = 1'b0;
        t_tick   = 1'b0;
        unique case (state)
            ST_IDLE:    state_n = ST_REQ_RD;
            ST_REQ_RD:  state_n = ST_REQ_CHK;
            ST_REQ_CHK: state_n = (bus_rdata == DW'(START_REQ)) ? ST_SCAN : ST_REQ_RD;
            ST_SCAN: begin
                if (scan_end) begin
                    pend_n  = (b_cnt != '0) ? PD_BURST : PD_FIN;
                    state_n = ST_BSY_RD;
                end else if (!img_present) begin
                    idx_n = idx + IAW'(1);
                    if (b_cnt != '0) begin
                        pend_n  = PD_BURST;
                        state_n = ST_BSY_RD;
                    end
                end else if (!opened) begin
                    pend_n  = PD_OPEN;
                    state_n = ST_BSY_RD;
                end else begin
                    idx_n = idx + IAW'(1);
                    b_inc = 1'b1;
                    if (b_last) begin
                        pend_n  = PD_BURST;
                        state_n = ST_BSY_RD;
                    end
                end
            end
            ST_BSY_RD:  state_n = ST_BSY_CHK;
            ST_BSY_CHK: begin
                if (busy) begin
                    if (t_exp) begin
                        state_n = ST_ERR;
                    end else begin
                        t_tick  = 1'b1;
                        state_n = ST_BSY_RD;
                    end
                end else begin
                    unique case (pend)
                        PD_OPEN:  state_n = ST_OPEN;
                        PD_BURST: state_n = ST_CMD;
                        default:  state_n = ST_FIN;
                    endcase
                end
            end
            ST_OPEN: begin
                opened_n = 1'b1;
                state_n  = ST_SCAN;
            end
            ST_CMD: begin
                b_clr    = 1'b1;
                opened_n = 1'b0;
                state_n  = ST_SCAN;
            end
            ST_FIN:  state_n = ST_DONE;
            ST_DONE: state_n = ST_HALT;
            ST_HALT: state_n = ST_HALT;
            ST_ERR:  state_n = ST_ERR;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        boot_done = 1'b0;
        boot_err  = 1'b0;
        unique case (state)
            ST_REQ_RD: begin
                bus_rd   = 1'b1;
                bus_addr = REQ_ADDR;
            end
            ST_BSY_RD: begin
                bus_rd   = 1'b1;
                bus_addr = STAT_ADDR;
            end
            ST_SCAN: begin
                if (scan_wr) begin
                    bus_wr    = 1'b1;
                    bus_addr  = DATA_BASE + AW'(b_cnt) + AW'(1);
                    bus_wdata = img_word;
                end
            end
            ST_OPEN: begin
                bus_wr    = 1'b1;
                bus_addr  = DATA_BASE;
                bus_wdata = DW'(idx);
            end
            ST_CMD: begin
                bus_wr    = 1'b1;
                bus_addr  = CMD_ADDR;
                bus_wdata = DW'(WRITE_CMD | 8'(b_cnt));
            end
            ST_FIN: begin
                bus_wr    = 1'b1;
                bus_addr  = CMD_ADDR;
                bus_wdata = DW'(FINISH_CMD);
            end
            ST_DONE: boot_done = 1'b1;
            ST_ERR:  boot_err  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mbx_boot_chk.sv
module mbx_boot_chk #(
    parameter int            AW        = 8,
    parameter int            DW        = 16,
    parameter int            MAX_BURST = 15,
    parameter int            BUSY_BIT  = 7,
    parameter logic [AW-1:0] CMD_ADDR  = 8'h40,
    parameter logic [AW-1:0] STAT_ADDR = 8'h41,
    parameter logic [AW-1:0] DATA_BASE = 8'h20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          boot_done,
    input logic          boot_err
);

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == CMD_ADDR);

    // R4: command only after a status read that showed busy clear
    a_r4_cmd_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> ($past(bus_rd, 2) && ($past(bus_addr, 2) == STAT_ADDR)
                    && !$past(bus_rdata[BUSY_BIT])));

    // R4: never a read and a write together
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R2: command codes limited to finish or a 1..MAX_BURST write
    a_r2_cmd_code: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (bus_wdata == DW'(8'h1F)) ||
                   ((bus_wdata[DW-1:4] == (DW-4)'(4'hA)) && (bus_wdata[3:0] != 4'd0)
                    && (int'(bus_wdata[3:0]) <= MAX_BURST)));

    // R3: writes go only to the data slots or the command register
    a_r3_wr_window: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == CMD_ADDR) ||
                   ((bus_addr >= DATA_BASE) && (bus_addr <= DATA_BASE + AW'(MAX_BURST))));

    // R8: done follows the finish write and lasts one cycle
    a_r8_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> $past(bus_wr && (bus_addr == CMD_ADDR) && (bus_wdata == DW'(8'h1F))));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !boot_done);

    // R9: error is sticky and silences the bus
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> boot_err);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> (!bus_wr && !bus_rd && !boot_done));

endmodule

bind mbx_boot_seq mbx_boot_chk #(
    .AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .BUSY_BIT(BUSY_BIT),
    .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .boot_done (boot_done),
    .boot_err  (boot_err)
);

// File: tb/sim_mbx_boot_seq.sv
module sim_mbx_boot_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_wr, bus_rd;
    logic [15:0] bus_rdata = '0;
    logic [6:0]  img_idx;
    logic        img_present, img_is_data;
    logic [15:0] img_word;
    logic [15:0] timeout_lim = 16'd1000;
    logic        boot_done, boot_err;

    always #10 clk = ~clk;

    mbx_boot_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata),
        .img_idx(img_idx), .img_present(img_present), .img_is_data(img_is_data),
        .img_word(img_word), .timeout_lim(timeout_lim),
        .boot_done(boot_done), .boot_err(boot_err)
    );

    // Image held by the bench
    logic [63:0] img_p, img_d;
    logic [15:0] img_w [64];

    assign img_present = (img_idx < 7'd64) ? img_p[img_idx[5:0]] : 1'b0;
    assign img_is_data = (img_idx < 7'd64) ? img_d[img_idx[5:0]] : 1'b0;
    assign img_word    = (img_idx < 7'd64) ? img_w[img_idx[5:0]] : 16'h0;

    // Scoreboard queues
    logic [7:0]  exp_cmd  [$];
    logic [15:0] exp_addr [$];
    logic [15:0] exp_word [$];

    int n_chk = 0, n_fail = 0;
    int wr_cnt, cmd_cnt, fin_cnt, done_cnt, stat_rd_cnt;
    logic [15:0] req_val;
    logic        stuck;
    int          busy_lat, busy_cnt;
    logic [15:0] mreg [16];
    bit          summary_done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: expected bursts from the image, per R2, R3, R5, R6
    task automatic push_burst(input int n, input int start);
        exp_cmd.push_back(8'hA0 | 8'(n));
        exp_addr.push_back(16'(start));
    endtask

    task automatic build_expect();
        int n = 0;
        int start = 0;
        for (int i = 0; i < 64; i++) begin
            if (img_d[i]) break;
            if (img_p[i]) begin
                if (n == 0) start = i;
                exp_word.push_back(img_w[i]);
                n++;
                if (n == 15) begin
                    push_burst(n, start);
                    n = 0;
                end
            end else if (n > 0) begin
                push_burst(n, start);
                n = 0;
            end
        end
        if (n > 0) push_burst(n, start);
    endtask

    // Mailbox model and monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_cnt = 0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (boot_done) done_cnt++;
            if (bus_rd) begin
                if (bus_addr == 8'h41) begin
                    stat_rd_cnt++;
                    bus_rdata <= (stuck || busy_cnt != 0) ? 16'h0080 : 16'h0000;
                end else if (bus_addr == 8'h42) begin
                    bus_rdata <= req_val;
                end else begin
                    bus_rdata <= 16'h0;
                end
            end
            if (bus_wr) begin
                wr_cnt++;
                if (req_val != 16'h001F)
                    chk(0, "R1 write before start request", bus_addr, 0);
                if (bus_addr >= 8'h20 && bus_addr < 8'h30) begin
                    mreg[bus_addr - 8'h20] = bus_wdata;
                end else if (bus_addr == 8'h40) begin
                    chk(!stuck && busy_cnt == 0, "R4 command while busy", busy_cnt, 0);
                    if (bus_wdata == 16'h001F) begin
                        fin_cnt++;
                        chk(exp_cmd.size() == 0, "R7 finish before all bursts", exp_cmd.size(), 0);
                    end else if (exp_cmd.size() == 0) begin
                        chk(0, "R6 unexpected burst", bus_wdata, 0);
                    end else begin
                        logic [7:0]  ec;
                        logic [15:0] ea;
                        ec = exp_cmd.pop_front();
                        ea = exp_addr.pop_front();
                        cmd_cnt++;
                        chk(bus_wdata == 16'(ec), "R2 burst command", bus_wdata, ec);
                        chk(mreg[0] == ea, "R3 R5 burst destination", mreg[0], ea);
                        for (int k = 1; k <= int'(ec[3:0]); k++) begin
                            logic [15:0] ew;
                            ew = exp_word.pop_front();
                            chk(mreg[k] == ew, "R3 burst word", mreg[k], ew);
                        end
                    end
                    busy_cnt = busy_lat;
                end
            end
        end
    end

    task automatic clear_img();
        img_p = '0;
        img_d = '0;
        for (int i = 0; i < 64; i++) img_w[i] = 16'(16'h5A00 + i * 16'h0101);
    endtask

    task automatic start_case(input int lat, input bit stk, input int lim);
        @(negedge clk);
        rst_n = 1'b0;
        req_val = 16'h0;
        stuck = stk;
        busy_lat = lat;
        timeout_lim = 16'(lim);
        wr_cnt = 0; cmd_cnt = 0; fin_cnt = 0; done_cnt = 0; stat_rd_cnt = 0;
        for (int k = 0; k < 16; k++) mreg[k] = 16'hDEAD;
        exp_cmd.delete(); exp_addr.delete(); exp_word.delete();
        build_expect();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: no write while the request register reads anything else
        req_val = 16'h0011;
        repeat (30) @(negedge clk);
        chk(wr_cnt == 0, "R1 idle before request", wr_cnt, 0);
        req_val = 16'h001F;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (boot_done || boot_err) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic end_ok(input int bursts);
        chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        chk(fin_cnt == 1, "R7 one finish command", fin_cnt, 1);
        chk(cmd_cnt == bursts, "R6 burst count", cmd_cnt, bursts);
        chk(exp_cmd.size() == 0 && exp_word.size() == 0, "R5 R6 scoreboard drained",
            exp_word.size(), 0);
        chk(boot_err == 1'b0, "R9 no error", boot_err, 0);
    endtask

    initial begin
        #(200000 * 20);
        chk(0, "watchdog expired", 0, 1);
        if (!summary_done) begin
            summary_done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        req_val = 16'h0; stuck = 1'b0; busy_lat = 5;
        clear_img();
        repeat (2) @(negedge clk);
        // R10: reset state
        chk(boot_done == 1'b0, "R10 done low in reset", boot_done, 0);
        chk(boot_err == 1'b0, "R10 err low in reset", boot_err, 0);
        chk(bus_wr == 1'b0, "R10 no write in reset", bus_wr, 0);

        // Case A: 20 contiguous words then data -> 15 + 5 (R2 R3 R6)
        clear_img();
        for (int i = 0; i < 20; i++) img_p[i] = 1'b1;
        img_d[20] = 1'b1; img_p[21] = 1'b1;
        start_case(7, 1'b0, 1000);
        end_ok(2);

        // Case B: gaps and code after the data tag (R5 R6)
        clear_img();
        img_p[0] = 1; img_p[1] = 1; img_p[2] = 1;
        img_p[4] = 1; img_p[5] = 1;
        img_p[8] = 1;
        img_p[10] = 1; img_p[11] = 1;
        img_d[12] = 1; img_p[12] = 1; img_p[13] = 1;
        start_case(3, 1'b0, 1000);
        end_ok(4);

        // Case C: exactly 15 words starting at 30 (R2 boundary)
        clear_img();
        for (int i = 30; i < 45; i++) img_p[i] = 1'b1;
        img_d[45] = 1'b1;
        start_case(12, 1'b0, 1000);
        end_ok(1);

        // Case D: data tag at entry 0 -> finish only (R6 R7)
        clear_img();
        img_d[0] = 1'b1; img_p[0] = 1'b1; img_p[1] = 1'b1;
        start_case(4, 1'b0, 1000);
        end_ok(0);

        // Case E: full image, no data tag -> 15,15,15,15,4 (R6 end of image)
        clear_img();
        img_p = '1;
        start_case(2, 1'b0, 1000);
        end_ok(5);

        // Case F: busy stuck -> error after lim+1 busy reads (R9)
        clear_img();
        for (int i = 0; i < 4; i++) img_p[i] = 1'b1;
        start_case(0, 1'b1, 5);
        chk(boot_err == 1'b1, "R9 error raised", boot_err, 1);
        chk(stat_rd_cnt == 6, "R9 busy reads before error", stat_rd_cnt, 6);
        chk(wr_cnt == 0, "R9 nothing written", wr_cnt, 0);
        chk(done_cnt == 0, "R9 no done", done_cnt, 0);
        repeat (20) @(negedge clk);
        chk(boot_err == 1'b1 && wr_cnt == 0, "R9 error sticky and quiet", boot_err, 1);

        if (!summary_done) begin
            summary_done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

endmodule